// File: doc/BRIEF.md
# Serial Transmitter with Infrared Pulse Encoder

This block turns bytes written by a host into an asynchronous serial bit stream. Bytes are queued in a small buffer that holds up to sixteen entries, or a single entry when the buffer is switched off. A framing engine takes each byte and sends it as a frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts sixteen periods of an oversampling tick that comes from outside the block.

In infrared mode the wired serial line stays at its idle high level. Each zero bit of the frame becomes a short low pulse on a separate active-low output. That pulse is either three oversampling ticks wide, centred in the bit, or, in low-power mode, three periods of a separate slow tick. The infrared link is half-duplex, so the block drives a gate signal that tells the receive side to ignore its input while a frame is being sent.

Top module: `sir_uart_tx`

## Requirements
- R1: With `fifo_on`=1 the buffer holds 16 bytes. `buf_full` is high when it holds 16. A write while `buf_full` is high is dropped. With the framing engine also holding one byte, 18 writes on back-to-back cycles starting from idle accept the first 17 and drop the 18th.
- R2: With `fifo_on`=0 the buffer holds one byte. Three writes on back-to-back cycles starting from idle accept the first and third and drop the second.
- R3: A frame on `txd` is a start bit at 0, the data bits least significant bit first, the parity bit if enabled, then the stop bits at 1. Each bit lasts 16 pulses of `tick16`, and `txd` changes only on a tick or when a frame starts.
- R4: `data_len` selects the number of data bits as 5 + `data_len` (00=5, 01=6, 10=7, 11=8). Only the low bits of the byte are sent.
- R5: When `par_on`=1, the parity bit is the XOR of the data bits sent, inverted when `par_odd`=1.
- R6: `stop2`=0 sends one stop bit and `stop2`=1 sends two. The next frame's start bit follows directly after the last stop bit.
- R7: While `ir_on`=1, `txd` stays at 1.
- R8: With `ir_on`=1 and `ir_lowpwr`=0, each zero bit of the frame gives one low pulse on `ir_out_n` lasting exactly 3 `tick16` periods. One bits give no pulse. With `ir_on`=0, `ir_out_n` stays at 1.
- R9: With `ir_on`=1 and `ir_lowpwr`=1, each zero bit gives one low pulse that ends on the third `lp_tick` after it begins. Its length in clocks is therefore above 2 and at most 3 `lp_tick` periods.
- R10: `rx_block` is high while a frame is being sent in infrared mode. It is 0 whenever `ir_on`=0.
- R11: `busy` rises the cycle after a byte is accepted. It stays high while any byte is buffered or being sent, through the end of the last stop bit. After reset it is 0, `txd` and `ir_out_n` are 1, and `buf_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| lp_tick | input | 1 | One-cycle pulse that times low-power infrared pulses |
| wr_en | input | 1 | Write a byte into the buffer |
| wr_data | input | 8 | Byte to write |
| fifo_on | input | 1 | 1: 16-entry buffer, 0: single holding byte |
| data_len | input | 2 | Data bits minus five |
| par_on | input | 1 | Send a parity bit |
| par_odd | input | 1 | Odd parity when set |
| stop2 | input | 1 | Two stop bits when set |
| ir_on | input | 1 | Infrared mode |
| ir_lowpwr | input | 1 | Low-power infrared pulse timing |
| txd | output | 1 | Serial line, idle high |
| ir_out_n | output | 1 | Active-low infrared pulse output |
| busy | output | 1 | Data buffered or in flight |
| buf_full | output | 1 | Buffer cannot take a write |
| rx_block | output | 1 | Receive gate during infrared sending |

## Verification
The assertions check on every cycle that the buffer never goes past its capacity and is never read when empty, and that `txd` moves only on a tick or when a frame starts. They also check that `txd` stays parked in infrared mode, that an infrared pulse never appears outside infrared mode, and that the low-power pulse counter stays in range. They check as well that the receive gate and the idle outputs agree with `busy`. The frame contents can only be shown by the bench's scenarios: the bit order, word length, parity value, the count of stop bits between frames, which writes are dropped at capacity, and the exact width and number of the infrared pulses.

// File: rtl/sirtx_pkg.sv
package sirtx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} txst_e;

  // number of data bits for a length code
  function automatic logic [3:0] bits_of(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // parity over the bits actually sent
  function automatic logic par_of(input logic [7:0] d, input logic [1:0] len,
                                  input logic odd);
    logic [7:0] msk;
    msk = 8'hFF >> (2'd3 - len);
    return (^(d & msk)) ^ odd;
  endfunction
endpackage

// File: rtl/tx_buf.sv
module tx_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_on,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cap;
  logic          wr_ok;

  assign cap   = fifo_on ? CW'(DEPTH) : CW'(1);
  assign full  = (cnt >= cap);
  assign empty = (cnt == '0);
  assign wr_ok = wr && !full;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd)    rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(rd);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !empty); // R1
  AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && $past(!fifo_on)) |-> cnt <= CW'(1)); // R2
endmodule

// File: rtl/tx_frame.sv
module tx_frame
  import sirtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       avail,
  input  logic [7:0] din,
  input  logic [1:0] data_len,
  input  logic       par_on,
  input  logic       par_odd,
  input  logic       stop2,
  output logic       pop,
  output logic       line,
  output logic       active,
  output logic       zero_win,
  output logic       zero_mid
);
  txst_e      st;
  logic [3:0] sub;
  logic [7:0] sh;
  logic [2:0] idx;
  logic [1:0] len_q;
  logic       pen_q, ts_q, par_q;
  logic       cur_bit, bit_end, last_data, stop_last, load;

  always_comb begin
    unique case (st)
      ST_START: cur_bit = 1'b0;
      ST_DATA:  cur_bit = sh[0];
      ST_PAR:   cur_bit = par_q;
      default:  cur_bit = 1'b1;
    endcase
  end

  assign active    = (st != ST_IDLE);
  assign line      = cur_bit;
  assign bit_end   = tick && (sub == 4'd15);
  assign last_data = ({1'b0, idx} == bits_of(len_q) - 4'd1);
  assign stop_last = (st == ST_STOP) && (!ts_q || idx == 3'd1);
  assign load      = avail && (!active || (stop_last && bit_end));
  assign pop       = load;
  assign zero_win  = active && !cur_bit && (sub >= 4'd6) && (sub <= 4'd8);
  assign zero_mid  = tick && active && !cur_bit && (sub == 4'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sub <= '0; sh <= '0; idx <= '0;
      len_q <= '0; pen_q <= 1'b0; ts_q <= 1'b0; par_q <= 1'b0;
    end else if (load) begin
      st    <= ST_START;
      sub   <= '0;
      sh    <= din;
      idx   <= '0;
      len_q <= data_len;
      pen_q <= par_on;
      ts_q  <= stop2;
      par_q <= par_of(din, data_len, par_odd);
    end else if (active && tick) begin
      sub <= sub + 4'd1;
      if (sub == 4'd15) begin
        unique case (st)
          ST_START: begin st <= ST_DATA; idx <= '0; end
          ST_DATA: begin
            sh <= sh >> 1;
            if (last_data) begin
              st  <= pen_q ? ST_PAR : ST_STOP;
              idx <= '0;
            end else idx <= idx + 3'd1;
          end
          ST_PAR: begin st <= ST_STOP; idx <= '0; end
          ST_STOP: begin
            if (stop_last) st <= ST_IDLE;
            else idx <= 3'd1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(load)) |-> $stable(line)); // R3
  AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (!active || bit_end)); // R6
endmodule

// File: rtl/sir_enc.sv
module sir_enc #(
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ir_on,
  input  logic lowpwr,
  input  logic zero_win,
  input  logic zero_mid,
  input  logic lp_tick,
  output logic out_n
);
  localparam int CNTW = $clog2(PW + 1);

  logic            run;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (zero_mid && lowpwr) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run && lp_tick) begin
      if (cnt == CNTW'(PW - 1)) run <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign out_n = ~(ir_on & (lowpwr ? run : zero_win));

  AST_LP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < CNTW'(PW)); // R9
  AST_PULSE_ONLY_IR: assert property (@(posedge clk) disable iff (!rst_n)
    !out_n |-> ir_on); // R8
endmodule

// File: rtl/sir_uart_tx.sv
module sir_uart_tx #(
  parameter int DEPTH = 16,
  parameter int IR_PW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       lp_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_on,
  input  logic [1:0] data_len,
  input  logic       par_on,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic       ir_on,
  input  logic       ir_lowpwr,
  output logic       txd,
  output logic       ir_out_n,
  output logic       busy,
  output logic       buf_full,
  output logic       rx_block
);
  logic [7:0] rd_byte;
  logic       empty, pop, line, active, zero_win, zero_mid;

  tx_buf #(.W(8), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .wr(wr_en), .wdata(wr_data),
    .rd(pop), .rdata(rd_byte), .empty(empty), .full(buf_full)
  );

  tx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .avail(!empty), .din(rd_byte),
    .data_len(data_len), .par_on(par_on), .par_odd(par_odd), .stop2(stop2),
    .pop(pop), .line(line), .active(active), .zero_win(zero_win),
    .zero_mid(zero_mid)
  );

  sir_enc #(.PW(IR_PW)) u_enc (
    .clk(clk), .rst_n(rst_n), .ir_on(ir_on), .lowpwr(ir_lowpwr),
    .zero_win(zero_win), .zero_mid(zero_mid), .lp_tick(lp_tick),
    .out_n(ir_out_n)
  );

  assign txd      = ir_on ? 1'b1 : line;
  assign busy     = active || !empty;
  assign rx_block = ir_on && active;

  AST_IR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    ir_on |-> txd); // R7
  AST_GATE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_block |-> busy); // R10
  AST_IDLE_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd && !buf_full)); // R11
  AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !buf_full) |=> busy); // R11
endmodule

// File: tb/tb_sir_uart_tx.sv
module tb_sir_uart_tx;
  localparam int TDIV = 4;
  localparam int LPDIV = 5;

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] len;
    logic       pe, po, ts;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick16 = 1'b0, lp_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic fifo_on = 1'b1, par_on = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic ir_on = 1'b0, ir_lowpwr = 1'b0;
  logic [1:0] data_len = 2'd3;
  logic txd, ir_out_n, busy, buf_full, rx_block;

  int n_chk = 0, n_bad = 0;
  int tdiv = 0, ldiv = 0;
  bit done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  sir_uart_tx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .lp_tick(lp_tick),
    .wr_en(wr_en), .wr_data(wr_data), .fifo_on(fifo_on), .data_len(data_len),
    .par_on(par_on), .par_odd(par_odd), .stop2(stop2), .ir_on(ir_on),
    .ir_lowpwr(ir_lowpwr), .txd(txd), .ir_out_n(ir_out_n), .busy(busy),
    .buf_full(buf_full), .rx_block(rx_block)
  );

  always @(posedge clk) begin
    tdiv    <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick16  <= (tdiv == TDIV - 1);
    ldiv    <= (ldiv == LPDIV - 1) ? 0 : ldiv + 1;
    lp_tick <= (ldiv == LPDIV - 1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int nbits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic ref_par(input exp_t e);
    int ones = 0;
    for (int i = 0; i < nbits(e.len); i++) ones += int'(e.d[i]);
    return logic'(ones % 2) ^ e.po;
  endfunction

  function automatic int zeros_in(input exp_t e);
    int z = 1;
    for (int i = 0; i < nbits(e.len); i++) if (!e.d[i]) z++;
    if (e.pe && !ref_par(e)) z++;
    return z;
  endfunction

  // caller stands at a negedge; returns whether the byte was accepted
  task automatic put(input logic [7:0] d, input bit push, output bit acc);
    exp_t e;
    acc = !buf_full;
    wr_en = 1'b1;
    wr_data = d;
    e = '{d: d, len: data_len, pe: par_on, po: par_odd, ts: stop2};
    if (acc && push) q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick16);
    end
  endtask

  task automatic drain();
    do @(negedge clk); while (busy || q.size() != 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic decode();
    exp_t e;
    logic [7:0] got;
    logic s0, pb, sa, sb;
    got = '0;
    wait_ticks(8);
    s0 = txd;
    check(busy && !rx_block, "R11/R10 busy,gate at start", {busy, rx_block}, 2);
    if (q.size() == 0) begin
      check(0, "R3 unexpected frame", 0, 1);
      return;
    end
    e = q.pop_front();
    for (int i = 0; i < nbits(e.len); i++) begin
      wait_ticks(16);
      got[i] = txd;
    end
    pb = 1'b1;
    if (e.pe) begin
      wait_ticks(16);
      pb = txd;
    end
    wait_ticks(16);
    sa = txd;
    check(busy, "R11 busy in stop", int'(busy), 1);
    sb = 1'b1;
    if (e.ts) begin
      wait_ticks(16);
      sb = txd;
      check(busy, "R11 busy in 2nd stop", int'(busy), 1);
    end
    check(s0 == 1'b0, "R3 start bit", int'(s0), 0);
    check(got == (e.d & (8'hFF >> (3 - int'(e.len)))), "R3/R4 data bits",
          int'(got), int'(e.d & (8'hFF >> (3 - int'(e.len)))));
    if (e.pe) check(pb == ref_par(e), "R5 parity", int'(pb), int'(ref_par(e)));
    check(sa && sb, "R6 stop bits", int'({sa, sb}), 3);
  endtask

  // monitor
  initial begin
    logic prev;
    prev = 1'b1;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (!ir_on && prev && !txd) decode();
      prev = txd;
    end
  end

  task automatic ir_frame(input logic [7:0] d, input bit lp);
    exp_t e;
    bit acc;
    int w, pulses, badw, badtx, badgate;
    e = '{d: d, len: data_len, pe: par_on, po: par_odd, ts: stop2};
    w = 0; pulses = 0; badw = 0; badtx = 0; badgate = 0;
    put(d, 0, acc);
    while (busy) begin
      if (!txd) badtx++;
      if (!ir_out_n) begin
        w++;
        if (!rx_block) badgate++;
      end else if (w > 0) begin
        pulses++;
        if (lp) begin
          if (w < 2 * LPDIV + 1 || w > 3 * LPDIV) badw = w;
        end else if (w != 3 * TDIV) badw = w;
        w = 0;
      end
      @(negedge clk);
    end
    check(badtx == 0, "R7 txd parked", badtx, 0);
    check(badgate == 0, "R10 gate during pulses", badgate, 0);
    check(pulses == zeros_in(e), lp ? "R9 pulse count" : "R8 pulse count",
          pulses, zeros_in(e));
    check(badw == 0, lp ? "R9 pulse width" : "R8 pulse width", badw, 0);
    check(!rx_block, "R10 gate released", int'(rx_block), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit acc;
    int nacc;
    bit flags[18];
    int hiout;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd && ir_out_n && !busy && !buf_full && !rx_block, "R11 reset state",
          int'({txd, ir_out_n, busy, buf_full, rx_block}), 5'b11000);

    // R3 8N1
    put(8'h55, 1, acc);
    check(busy, "R11 busy after write", int'(busy), 1);
    put(8'hA3, 1, acc);
    hiout = 0;
    do begin
      @(negedge clk);
      if (!ir_out_n) hiout++;
    end while (busy || q.size() != 0);
    check(hiout == 0, "R8 no ir pulse in wired mode", hiout, 0);
    check(!busy && txd, "R11 idle after frames", int'({busy, txd}), 1);

    // R4 word lengths
    for (int l = 0; l < 3; l++) begin
      data_len = 2'(l);
      put(8'hE6 ^ 8'(l), 1, acc);
      drain();
    end

    // R5 parity, 7 bits
    data_len = 2'd2; par_on = 1'b1;
    par_odd = 1'b0; put(8'h13, 1, acc); drain();
    par_odd = 1'b1; put(8'h13, 1, acc); drain();
    par_odd = 1'b0; put(8'h7F, 1, acc); drain();

    // R6 two stop bits, back to back
    par_on = 1'b0; data_len = 2'd3; stop2 = 1'b1;
    put(8'h00, 1, acc); put(8'hFE, 1, acc); put(8'h80, 1, acc);
    drain();
    stop2 = 1'b0;

    // R1 FIFO capacity
    nacc = 0;
    for (int i = 0; i < 18; i++) begin
      put(8'(8'h30 + i), 1, acc);
      flags[i] = acc;
      nacc += int'(acc);
    end
    check(nacc == 17, "R1 accepted count", nacc, 17);
    check(!flags[17] && flags[16], "R1 drop at full", int'({flags[16], flags[17]}), 2);
    drain();

    // R2 holding register
    fifo_on = 1'b0;
    put(8'h11, 1, acc); flags[0] = acc;
    put(8'h22, 1, acc); flags[1] = acc;
    put(8'h33, 1, acc); flags[2] = acc;
    check(flags[0] && !flags[1] && flags[2], "R2 holding accepts",
          int'({flags[0], flags[1], flags[2]}), 5);
    drain();
    fifo_on = 1'b1;

    // R8 normal infrared, R9 low power
    ir_on = 1'b1;
    ir_frame(8'h0F, 0);
    par_on = 1'b1;
    ir_frame(8'h5A, 0);
    par_on = 1'b0;
    ir_lowpwr = 1'b1;
    data_len = 2'd0;
    ir_frame(8'h00, 1);
    ir_frame(8'h16, 1);
    ir_on = 1'b0; ir_lowpwr = 1'b0; data_len = 2'd3;
    repeat (4) @(negedge clk);
    check(txd && ir_out_n && !rx_block, "R10 wired mode restored",
          int'({txd, ir_out_n, rx_block}), 6);
    put(8'hC4, 1, acc);
    drain();

    summary();
  end
endmodule